// File: doc/BRIEF.md
# Pretrigger Capture Address Controller

This block steers the write side of a circular sample memory so that a chosen number of samples taken before a trigger event are kept, together with the samples that follow it. Once armed, a ring pointer starts at address 0. It steps once for every valid sample and wraps from the last address back to 0. When a trigger is accepted, a second counter is preloaded with the requested pretrigger depth. That counter then advances with every stored sample. When it reaches the memory size, writing stops, just before the oldest wanted sample would be overwritten.

At the stop point the ring pointer names the oldest retained word. It is presented as the read start address for whatever logic drains the memory. A trigger is accepted only after enough samples have been stored since arming to fill the requested pretrigger window. A depth of zero gives a capture made only of post-trigger samples. The done flag stays up until the block is armed again.

Outputs are registered. The write strobe and address for a sample appear one clock after that sample is presented, so the sample data path must be delayed by one register to line up with them.

Top module: `pretrig_capture_ctrl`

## Requirements
- R1: After reset, wr_en_o, done_o, wr_addr_o and rd_start_o are all 0.
- R2: While capturing, every cycle with sample_vld_i high produces, one clock later, wr_en_o high with wr_addr_o equal to the next ring address. The first write after arming goes to address 0, and the address wraps from DEPTH-1 to 0. Cycles without sample_vld_i produce no write.
- R3: Before the first arm_i after reset, no write occurs and done_o stays low, whatever sample_vld_i and trig_i do.
- R4: While capturing, trig_i is ignored unless the number of samples stored since arming is at least pre_depth_i.
- R5: After an accepted trigger, exactly DEPTH - pre_depth_i further samples are written and then writing stops. A sample presented in the same cycle as the accepted trigger counts as the first of them.
- R6: At the stop, rd_start_o equals (A + DEPTH - pre_depth_i) mod DEPTH, where A is the ring address due for the next write when the trigger was accepted. With depth 300 and A = 900 this gives 600.
- R7: With pre_depth_i = 0 the trigger is accepted at once after arming, DEPTH post-trigger samples are written, and rd_start_o equals A.
- R8: done_o rises one clock after the last write strobe and stays high until arm_i. While done_o is high, wr_en_o is low, rd_start_o is stable, and samples and triggers have no effect.
- R9: arm_i clears done_o and restarts the capture with the ring at address 0. This holds from the done state and also during a capture in progress. A sample presented in the same cycle as arm_i is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start or restart a capture |
| sample_vld_i | input | 1 | A sample is present this cycle |
| trig_i | input | 1 | Trigger event |
| pre_depth_i | input | AW (10) | Number of pretrigger samples to keep, 0 to DEPTH-1 |
| wr_en_o | output | 1 | Memory write strobe, one clock after the sample |
| wr_addr_o | output | AW (10) | Memory write address paired with wr_en_o |
| done_o | output | 1 | Capture finished, held until re-arm |
| rd_start_o | output | AW (10) | Address of the oldest retained word |

## Verification
The main depth-300 run places an ignored trigger one sample short of the window, then an accepted trigger with the ring at 900. This separates a correct qualification rule from an off-by-one, and it checks the 724-write count and the wrapped start address 600. A small depth with the trigger arriving together with a sample shows whether that sample is counted as post-trigger data. Depth zero with a few samples before the trigger checks the full-length post-trigger capture. Further runs feed samples and triggers into a finished capture, and re-arm both from done and mid-capture, to show the freeze and the restart at address 0.

// File: rtl/scope_cap_pkg.sv
package scope_cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_FILL = 2'd1,
    CAP_POST = 2'd2,
    CAP_DONE = 2'd3
  } cap_state_t;
endpackage

// File: rtl/ring_addr_ctr.sv
module ring_addr_ctr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end

  p_ring_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (q == $past(q) + 1'b1));
  p_ring_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
endmodule

// File: rtl/pretrig_fill_ctr.sv
module pretrig_fill_ctr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [AW-1:0] depth,
  output logic          ready
);
  localparam logic [AW-1:0] FULL = {AW{1'b1}};
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)           cnt <= '0;
    else if (inc && cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt >= depth);

  p_fill_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL && !clr) |=> (cnt == FULL));
endmodule

// File: rtl/post_trig_ctr.sv
module post_trig_ctr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic          hit
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (load)  cnt <= load_val + {{(AW-1){1'b0}}, inc};
    else if (inc)   cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (load) hit = inc && (load_val == LAST);
    else      hit = inc && (cnt == LAST);
  end

  p_post_step_r5: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && !hit) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pretrig_capture_ctrl.sv
module pretrig_capture_ctrl
  import scope_cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          sample_vld_i,
  input  logic          trig_i,
  input  logic [AW-1:0] pre_depth_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          done_o,
  output logic [AW-1:0] rd_start_o
);
  cap_state_t    state, state_nx;
  logic [AW-1:0] ring;
  logic          fill_ready, post_hit;
  logic          wr, fill_inc, post_load, post_inc;

  always_comb begin
    state_nx  = state;
    wr        = 1'b0;
    fill_inc  = 1'b0;
    post_load = 1'b0;
    post_inc  = 1'b0;
    if (arm_i) begin
      state_nx = CAP_FILL;
    end else begin
      case (state)
        CAP_FILL: begin
          wr       = sample_vld_i;
          fill_inc = sample_vld_i;
          if (trig_i && fill_ready) begin
            post_load = 1'b1;
            post_inc  = sample_vld_i;
            state_nx  = post_hit ? CAP_DONE : CAP_POST;
          end
        end
        CAP_POST: begin
          wr       = sample_vld_i;
          post_inc = sample_vld_i;
          if (post_hit) state_nx = CAP_DONE;
        end
        default: state_nx = state;
      endcase
    end
  end

  ring_addr_ctr #(.AW(AW)) u_ring (
    .clk(clk), .rst(rst), .clr(arm_i), .inc(wr), .q(ring)
  );

  pretrig_fill_ctr #(.AW(AW)) u_fill (
    .clk(clk), .rst(rst), .clr(arm_i), .inc(fill_inc),
    .depth(pre_depth_i), .ready(fill_ready)
  );

  post_trig_ctr #(.AW(AW)) u_post (
    .clk(clk), .rst(rst), .load(post_load), .load_val(pre_depth_i),
    .inc(post_inc), .hit(post_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= CAP_IDLE;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      done_o     <= 1'b0;
      rd_start_o <= '0;
    end else begin
      state   <= state_nx;
      wr_en_o <= wr;
      if (wr) wr_addr_o <= ring;
      done_o  <= !arm_i && (state == CAP_DONE);
      if (!arm_i && state == CAP_DONE) rd_start_o <= ring;
    end
  end

  p_no_wr_when_done_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !wr_en_o);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> done_o);
  p_rd_start_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> $stable(rd_start_o));
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (state == CAP_IDLE) |=> !wr_en_o);
  p_arm_clears_r9: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (!done_o && !wr_en_o));
endmodule

// File: tb/sim_pretrig_capture_ctrl.sv
module sim_pretrig_capture_ctrl;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arm = 1'b0, vld = 1'b0, trg = 1'b0;
  logic [AW-1:0] dep = '0;
  logic          wr_en, done;
  logic [AW-1:0] wr_addr, rd_start;

  int checks = 0;
  int errors = 0;
  int exp_addr = 0;
  int addr_errs = 0;

  always #10 clk = ~clk;

  pretrig_capture_ctrl #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .arm_i(arm), .sample_vld_i(vld), .trig_i(trg),
    .pre_depth_i(dep), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .done_o(done), .rd_start_o(rd_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample at the following negedge
  task automatic cyc(input logic v, input logic t, input logic a);
    vld = v; trg = t; arm = a;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0; trg = 1'b0; arm = 1'b0;
    if (wr_en) begin
      if (int'(wr_addr) != exp_addr) begin
        addr_errs++;
        if (addr_errs < 4) check(1'b0, "R2 write address", int'(wr_addr), exp_addr);
      end
      exp_addr = (exp_addr + 1) % DEPTH;
    end
  endtask

  task automatic do_arm();
    cyc(1'b1, 1'b0, 1'b1);
    exp_addr = 0;
  endtask

  // feed samples until done; return number of writes seen
  task automatic run_to_done(output int n);
    n = 0;
    for (int i = 0; i < 2*DEPTH && !done; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      if (wr_en) n++;
    end
  endtask

  task automatic t_reset();
    check(wr_en == 0 && done == 0, "R1 reset flags", {wr_en, done}, 0);
    check(wr_addr == 0 && rd_start == 0, "R1 reset addrs", int'(wr_addr) + int'(rd_start), 0);
  endtask

  task automatic t_idle();
    int n = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, (i % 5) == 0, 1'b0);
      if (wr_en) n++;
    end
    check(n == 0, "R3 no writes before arm", n, 0);
    check(done == 0, "R3 done low before arm", done, 0);
  endtask

  task automatic t_depth300();
    int n;
    dep = 10'd300;
    do_arm();
    check(wr_en == 0, "R9 sample with arm not written", wr_en, 0);
    for (int i = 0; i < 299; i++) cyc(1'b1, 1'b0, 1'b0);
    check(exp_addr == 299, "R2 fill count", exp_addr, 299);
    cyc(1'b0, 1'b1, 1'b0);   // one short of depth: ignored
    for (int i = 0; i < 601; i++) cyc(1'b1, 1'b0, 1'b0);
    check(exp_addr == 900 && !done, "R4 early trigger ignored", exp_addr, 900);
    cyc(1'b0, 1'b1, 1'b0);   // accepted, ring at 900
    run_to_done(n);
    check(n == 724, "R5 post-trigger writes depth300", n, 724);
    check(rd_start == 10'd600, "R6 start address", int'(rd_start), 600);
    check(addr_errs == 0, "R2 wrapped address sequence", addr_errs, 0);
  endtask

  task automatic t_done_hold();
    int n = 0;
    logic [AW-1:0] rs;
    rs = rd_start;
    for (int i = 0; i < 30; i++) begin
      cyc(1'b1, (i % 3) == 0, 1'b0);
      if (wr_en) n++;
    end
    check(n == 0, "R8 no writes while done", n, 0);
    check(done == 1, "R8 done held", done, 1);
    check(rd_start == rs, "R8 start address stable", int'(rd_start), int'(rs));
  endtask

  task automatic t_trig_with_sample();
    int n;
    dep = 10'd5;
    do_arm();
    check(done == 0, "R9 arm clears done", done, 0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);   // trigger at exact depth, with sample at addr 5
    n = wr_en ? 1 : 0;
    check(wr_en == 1 && wr_addr == 10'd5, "R5 trigger-cycle sample written", int'(wr_addr), 5);
    begin
      int m;
      run_to_done(m);
      n += m;
    end
    check(n == DEPTH - 5, "R5 count incl trigger sample", n, DEPTH - 5);
    check(rd_start == 10'd0, "R6 start address depth5", int'(rd_start), 0);
  endtask

  task automatic t_depth0();
    int n;
    dep = 10'd0;
    do_arm();
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    run_to_done(n);
    check(n == DEPTH, "R7 full post-trigger length", n, DEPTH);
    check(rd_start == 10'd3, "R7 start at trigger address", int'(rd_start), 3);
  endtask

  task automatic t_rearm_mid();
    dep = 10'd0;
    do_arm();
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0);
    check(exp_addr == 10, "R2 pre-rearm writes", exp_addr, 10);
    do_arm();                 // sample in this cycle is dropped
    check(wr_en == 0, "R9 arm-cycle sample dropped", wr_en, 0);
    cyc(1'b1, 1'b0, 1'b0);
    check(wr_en == 1 && wr_addr == 0, "R9 restart at address 0", int'(wr_addr), 0);
    cyc(1'b0, 1'b0, 1'b0);
    check(wr_en == 0, "R2 no write without sample", wr_en, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_depth300();
    t_done_hold();
    t_trig_with_sample();
    t_depth0();
    t_rearm_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule